// File: doc/BRIEF.md
# Parallel-to-Serial Word Converter with Rate Select

The block takes an 8-bit parallel word and turns it into one serial NRZ bit stream, starting with bit 0. It also produces a parallel clock at the word rate, so the logic upstream knows when to present the next word.

A mode input picks one of two rates. In single rate, each input clock period carries one bit, and the output is retimed on the falling clock edge. In double rate, each period carries two bits: the output multiplexer shows the even bit of a pair while the clock is high and the odd bit while it is low.

A sync input clears the converter and restarts it on a defined edge sequence. An enable input freezes and resumes conversion synchronously. All state registers update on the rising edge. Only the arm register and the single-rate output retimer use the falling edge.

Top module: `p2s_serializer`

## Requirements
- R1: The bits of each word leave in ascending index order: data_i[0] first, data_i[7] last.
- R2: With rate_sel_i = 1 (single rate), one bit is shown per clock period. Each bit becomes valid at a falling edge and holds for one full period, so a word lasts 8 clocks.
- R3: With rate_sel_i = 0 (double rate), two bits are shown per clock period. The even-indexed bit of the pair is on sdata_o while clk_i is high, and the odd-indexed bit while clk_i is low.
- R4: pclk_o has a period of 8 serial bit times. It is 1 while bits 0 to 3 of a word are on the output and 0 while bits 4 to 7 are on it, so it rises as each word starts.
- R5: While sync_i is 1, all state is cleared at once: sdata_o = 0, pclk_o = 0, and the converter does not advance.
- R6: After sync_i falls, the first falling clock edge arms the converter. The first word is captured on the next rising edge, and no rising edge before that arming edge starts conversion.
- R7: data_i is captured only on the rising edge that starts a word. Changes at any other time have no effect. Consecutive words follow with no gap.
- R8: A rising edge with en_i = 0 advances nothing. sdata_o and pclk_o keep the level they last showed, and the next enabled edge resumes with the following bit.
- R9: rst_ni = 0 clears all state asynchronously: sdata_o = 0 and pclk_o = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sync_i | input | 1 | Clear while high; restart sequence after it falls |
| en_i | input | 1 | Synchronous conversion enable |
| rate_sel_i | input | 1 | 1: one bit per clock, 0: two bits per clock |
| data_i | input | W (8) | Parallel word, bit 0 sent first |
| sdata_o | output | 1 | Serial NRZ data |
| pclk_o | output | 1 | Word-rate clock for the upstream logic |

## Verification
The assertions assume the following about the inputs:
- rate_sel_i stays constant from the arming edge until the next sync or reset, so a double-rate pair always starts at an even index.
- data_i and en_i change away from rising clock edges.
- sync_i never toggles exactly on a clock edge.

The stimulus keeps within these limits. It changes rate_sel_i only while sync_i is high, drives every data, enable and sync change one to three time units after a clock edge, and places each captured word on data_i only in the cycle before its capture edge. At other times it leaves a complemented word on data_i.

// File: rtl/p2s_pkg.sv
package p2s_pkg;
  localparam int unsigned WORD_W = 8;

  typedef enum logic {
    RATE_DOUBLE = 1'b0,
    RATE_SINGLE = 1'b1
  } rate_e;
endpackage

// File: rtl/p2s_arm.sv
// Arms on the first falling clock edge after the clear is released.
module p2s_arm (
  input  logic clk_i,
  input  logic clr_ni,
  output logic armed_o
);
  logic armed_q;

  always_ff @(negedge clk_i or negedge clr_ni) begin
    if (!clr_ni) armed_q <= 1'b0;
    else         armed_q <= 1'b1;
  end

  assign armed_o = armed_q;
endmodule

// File: rtl/p2s_core.sv
module p2s_core #(
  parameter int unsigned W = p2s_pkg::WORD_W
) (
  input  logic                 clk_i,
  input  logic                 clr_ni,
  input  logic                 armed_i,
  input  logic                 en_i,
  input  logic                 single_i,
  input  logic [W-1:0]         data_i,
  output logic [$clog2(W)-1:0] cnt_o,
  output logic [W-1:0]         hold_o,
  output logic                 even_o,
  output logic                 odd_o,
  output logic                 pclk_o
);
  localparam int unsigned CW   = $clog2(W);
  localparam int unsigned HALF = W / 2;

  logic [CW-1:0] cnt_q, cnt_nxt, odd_idx;
  logic [W-1:0]  hold_q, word;
  logic          even_q, odd_q, pclk_q;
  logic          run, wrap;

  assign run     = armed_i & en_i;
  assign word    = (cnt_q == '0) ? data_i : hold_q;
  assign odd_idx = cnt_q | CW'(1);
  assign wrap    = single_i ? (cnt_q == CW'(W - 1)) : (cnt_q == CW'(W - 2));

  always_comb begin
    if (wrap)          cnt_nxt = '0;
    else if (single_i) cnt_nxt = cnt_q + CW'(1);
    else               cnt_nxt = cnt_q + CW'(2);
  end

  always_ff @(posedge clk_i or negedge clr_ni) begin
    if (!clr_ni) begin
      cnt_q  <= '0;
      hold_q <= '0;
      even_q <= 1'b0;
      odd_q  <= 1'b0;
      pclk_q <= 1'b0;
    end else if (run) begin
      if (cnt_q == '0) hold_q <= data_i;
      even_q <= word[cnt_q];
      odd_q  <= single_i ? 1'b0 : word[odd_idx];
      pclk_q <= (32'(cnt_q) < HALF);
      cnt_q  <= cnt_nxt;
    end else if (armed_i && !single_i) begin
      // halted in double rate: park on the odd bit so the mux output is flat
      even_q <= odd_q;
    end
  end

  assign cnt_o  = cnt_q;
  assign hold_o = hold_q;
  assign even_o = even_q;
  assign odd_o  = odd_q;
  assign pclk_o = pclk_q;
endmodule

// File: rtl/p2s_outmux.sv
module p2s_outmux (
  input  logic clk_i,
  input  logic clr_ni,
  input  logic single_i,
  input  logic even_i,
  input  logic odd_i,
  output logic sdata_o
);
  logic ret_q;

  always_ff @(negedge clk_i or negedge clr_ni) begin
    if (!clr_ni)       ret_q <= 1'b0;
    else if (single_i) ret_q <= even_i;
  end

  assign sdata_o = single_i ? ret_q : (clk_i ? even_i : odd_i);
endmodule

// File: rtl/p2s_serializer.sv
module p2s_serializer #(
  parameter int unsigned W = p2s_pkg::WORD_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         sync_i,
  input  logic         en_i,
  input  logic         rate_sel_i,
  input  logic [W-1:0] data_i,
  output logic         sdata_o,
  output logic         pclk_o
);
  import p2s_pkg::*;
  localparam int unsigned CW = $clog2(W);

  logic          clr_n, single, armed;
  logic [CW-1:0] cnt;
  logic [W-1:0]  hold;
  logic          even_b, odd_b;

  assign clr_n  = rst_ni & ~sync_i;
  assign single = (rate_e'(rate_sel_i) == RATE_SINGLE);

  p2s_arm u_arm (
    .clk_i   (clk_i),
    .clr_ni  (clr_n),
    .armed_o (armed)
  );

  p2s_core #(.W(W)) u_core (
    .clk_i    (clk_i),
    .clr_ni   (clr_n),
    .armed_i  (armed),
    .en_i     (en_i),
    .single_i (single),
    .data_i   (data_i),
    .cnt_o    (cnt),
    .hold_o   (hold),
    .even_o   (even_b),
    .odd_o    (odd_b),
    .pclk_o   (pclk_o)
  );

  p2s_outmux u_mux (
    .clk_i    (clk_i),
    .clr_ni   (clr_n),
    .single_i (single),
    .even_i   (even_b),
    .odd_i    (odd_b),
    .sdata_o  (sdata_o)
  );
endmodule

// File: rtl/p2s_serializer_chk.sv
module p2s_serializer_chk #(
  parameter int unsigned W  = p2s_pkg::WORD_W,
  parameter int unsigned CW = $clog2(W)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          sync_i,
  input logic          en_i,
  input logic          rate_sel_i,
  input logic [W-1:0]  data_i,
  input logic          pclk_o,
  input logic          armed,
  input logic [CW-1:0] cnt,
  input logic [W-1:0]  hold
);
  // R5
  sync_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_i |-> (cnt == '0) && !pclk_o && !armed);

  // R7
  word_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || sync_i)
    (armed && en_i && cnt == '0) |=> (hold == $past(data_i)));

  // R8
  halt_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || sync_i)
    (armed && !en_i) |=> ($stable(cnt) && $stable(pclk_o)));

  // R3
  pair_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || sync_i)
    (armed && !rate_sel_i) |-> (cnt[0] == 1'b0));

  // R4
  pclk_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || sync_i)
    (armed && en_i && cnt == '0) |=> pclk_o);

  // R4
  pclk_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || sync_i)
    (armed && en_i && cnt == CW'(W / 2)) |=> !pclk_o);
endmodule

bind p2s_serializer p2s_serializer_chk #(.W(W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .sync_i     (sync_i),
  .en_i       (en_i),
  .rate_sel_i (rate_sel_i),
  .data_i     (data_i),
  .pclk_o     (pclk_o),
  .armed      (armed),
  .cnt        (cnt),
  .hold       (hold)
);

// File: tb/sim_p2s_serializer.sv
module sim_p2s_serializer;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic  bit_v;
    logic  pclk_v;
    string req;
  } item_t;

  logic       clk, rst_ni, sync_i, en_i, rate_sel_i;
  logic [7:0] data_i;
  logic       sdata_o, pclk_o;
  logic       mon_on;
  int         checks, errors;
  item_t      sb_q[$];

  p2s_serializer u0 (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .sync_i     (sync_i),
    .en_i       (en_i),
    .rate_sel_i (rate_sel_i),
    .data_i     (data_i),
    .sdata_o    (sdata_o),
    .pclk_o     (pclk_o)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD / 2) clk = ~clk;
  end

  task automatic chk(input string req, input logic act_s, input logic exp_s,
                     input logic act_p, input logic exp_p);
    checks++;
    if (act_s !== exp_s || act_p !== exp_p) begin
      errors++;
      $display("FAIL %s: sdata=%b pclk=%b expected sdata=%b pclk=%b at %0t",
               req, act_s, act_p, exp_s, exp_p, $time);
    end
  endtask

  task automatic pop_cmp();
    item_t it;
    if (sb_q.size() == 0) begin
      checks++;
      errors++;
      $display("FAIL R1: unexpected sample sdata=%b expected none at %0t", sdata_o, $time);
    end else begin
      it = sb_q.pop_front();
      chk(it.req, sdata_o, it.bit_v, pclk_o, it.pclk_v);
    end
  endtask

  // monitor: single rate samples after falling edges, double rate after both
  initial forever begin
    @(posedge clk);
    #2;
    if (mon_on && !rate_sel_i) pop_cmp();
  end

  initial forever begin
    @(negedge clk);
    #2;
    if (mon_on) pop_cmp();
  end

  task automatic arm(input logic r, input logic [7:0] d);
    rate_sel_i = r;
    data_i     = d;
    sync_i     = 1'b1;
    en_i       = 1'b1;
    @(negedge clk);
    #2 sync_i = 1'b0;
    @(negedge clk);
  endtask

  // driver: queue the expected bits, then feed words one cycle ahead of capture
  task automatic stream(input logic r, input logic [7:0] w0, input logic [7:0] w1,
                        input logic [7:0] w2, input logic [7:0] w3, input string req);
    logic [7:0] ws[4];
    int per;
    ws  = '{w0, w1, w2, w3};
    per = r ? 8 : 4;
    foreach (ws[i])
      for (int k = 0; k < 8; k++)
        sb_q.push_back('{bit_v: ws[i][k], pclk_v: (k < 4), req: req});
    arm(r, ws[0]);
    #3 mon_on = 1'b1;
    for (int i = 1; i < 4; i++) begin
      @(posedge clk);
      #1 data_i = ~ws[i];            // R7: changes off the capture edge are ignored
      repeat (per - 1) @(posedge clk);
      #1 data_i = ws[i];
    end
    @(posedge clk);
    #1 data_i = 8'h00;
    repeat (per - 1) @(posedge clk);
    @(negedge clk);
    #3 mon_on = 1'b0;
    checks++;
    if (sb_q.size() != 0) begin
      errors++;
      $display("FAIL %s: %0d bits left expected 0", req, sb_q.size());
      sb_q.delete();
    end
    sync_i = 1'b1;
  endtask

  task automatic report();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not finish expected done");
    report();
  end

  initial begin
    checks = 0; errors = 0; mon_on = 1'b0;
    rst_ni = 1'b1; sync_i = 1'b0; en_i = 1'b1; rate_sel_i = 1'b1; data_i = 8'h00;
    #3 rst_ni = 1'b0;
    #1 chk("R9", sdata_o, 1'b0, pclk_o, 1'b0);
    sync_i = 1'b1;
    data_i = 8'hFF;
    repeat (2) @(posedge clk);
    #1 rst_ni = 1'b1;
    repeat (3) @(posedge clk);
    #2 chk("R5", sdata_o, 1'b0, pclk_o, 1'b0);

    // R1 R2 R4 R6 R7 single rate
    stream(1'b1, 8'hA5, 8'h3C, 8'h81, 8'h5E, "R2");
    // R1 R3 R4 R7 double rate
    stream(1'b0, 8'hC9, 8'h17, 8'hE4, 8'h6B, "R3");

    // R8 single rate halt after bit 2
    arm(1'b1, 8'h34);
    repeat (3) @(posedge clk);
    #1 en_i = 1'b0;
    @(negedge clk); #2 chk("R8", sdata_o, 1'b1, pclk_o, 1'b1);
    @(negedge clk); #2 chk("R8", sdata_o, 1'b1, pclk_o, 1'b1);
    @(negedge clk); #2 chk("R8", sdata_o, 1'b1, pclk_o, 1'b1);
    @(posedge clk); #1 en_i = 1'b1;
    @(negedge clk); #2 chk("R8", sdata_o, 1'b1, pclk_o, 1'b1);
    @(negedge clk); #2 chk("R8", sdata_o, 1'b0, pclk_o, 1'b1);
    @(negedge clk); #2 chk("R8", sdata_o, 1'b1, pclk_o, 1'b0);
    sync_i = 1'b1;

    // R8 double rate halt after pair 2/3
    arm(1'b0, 8'h34);
    repeat (2) @(posedge clk);
    #1 en_i = 1'b0;
    #1 chk("R8", sdata_o, 1'b1, pclk_o, 1'b1);
    @(negedge clk); #2 chk("R8", sdata_o, 1'b0, pclk_o, 1'b1);
    @(posedge clk); #2 chk("R8", sdata_o, 1'b0, pclk_o, 1'b1);
    @(negedge clk); #2 chk("R8", sdata_o, 1'b0, pclk_o, 1'b1);
    @(posedge clk); #1 en_i = 1'b1;
    #1 chk("R8", sdata_o, 1'b0, pclk_o, 1'b1);
    @(posedge clk); #2 chk("R8", sdata_o, 1'b1, pclk_o, 1'b0);
    @(negedge clk); #2 chk("R8", sdata_o, 1'b1, pclk_o, 1'b0);
    sync_i = 1'b1;

    // R5 sync raised mid-word
    arm(1'b1, 8'hFF);
    repeat (3) @(posedge clk);
    @(negedge clk); #2 chk("R5", sdata_o, 1'b1, pclk_o, 1'b1);
    sync_i = 1'b1;
    #1 chk("R5", sdata_o, 1'b0, pclk_o, 1'b0);
    repeat (3) @(posedge clk);
    #2 chk("R5", sdata_o, 1'b0, pclk_o, 1'b0);

    // R9 reset mid-word
    arm(1'b1, 8'hFF);
    repeat (3) @(posedge clk);
    @(negedge clk); #2 chk("R9", sdata_o, 1'b1, pclk_o, 1'b1);
    rst_ni = 1'b0;
    #1 chk("R9", sdata_o, 1'b0, pclk_o, 1'b0);
    sync_i = 1'b1;
    #2 rst_ni = 1'b1;
    repeat (2) @(posedge clk);
    report();
  end
endmodule